// File: doc/BRIEF.md
# Narrow SRAM Refill and Writethrough Sequencer

This block sits between a cache that works in 32-bit words and an external static RAM whose data bus is 16 bits wide, or 8 bits wide when the memory-map lookup reports a byte-wide device. It serves two kinds of request. A refill fetches a whole four-word cache line. A writethrough stores one 32-bit word, with per-byte enables. The block drives the chip address, the write data, an active-low output enable and two active-low write strobes, one per byte lane. It also controls when the data bus is driven.

Each request is accepted in one cycle while the block is idle. At that point the block also takes the wait-state count and the bus width from the memory-map lookup. Every bus access is stretched by that number of wait states. On a refill, the halfwords or bytes read back are packed into 32-bit words and passed to the cache data array with a word index and a write pulse. A single-cycle done pulse ends every operation.

Top module: `sram_narrow_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, busy_o, done_o and fill_we_o are 0, chip_oe_n_o is 1, chip_we_n_o is 2'b11 and chip_drive_o is 0.
- R2: A refill ignores the two low bits of addr_i. It returns four words of the line in order 0, 1, 2, 3 on fill_idx_o, each with a one-cycle fill_we_o. In 16-bit mode the first halfword read becomes bits 31:16 of the word. In 8-bit mode the four bytes fill bits 31:24 down to 7:0, and chip_din_i[15:8] is ignored.
- R3: Chip address is word address times 2 plus the halfword phase (0, 1) in 16-bit mode. It is word address times 4 plus the byte phase (0 to 3) in 8-bit mode. Phases run in ascending order.
- R4: Each read access holds its address with chip_oe_n_o low for ws+2 cycles: ws+1 access cycles plus one hold cycle. The input data is captured at the clock edge that ends the hold cycle.
- R5: A writethrough always performs two accesses in 16-bit mode and four in 8-bit mode, whatever wbe_i holds. An access whose bytes are all disabled keeps its strobes high.
- R6: Each write access has one setup cycle, ws+1 strobe cycles and one hold cycle. Address and data are stable and driven across the strobe's falling and rising edges.
- R7: In 16-bit mode, chip_we_n_o[1] and chip_dout_o[15:8] carry the higher-order byte of each halfword: word byte 3 in phase 0 and byte 1 in phase 1. wbe_i[j] enables bits 8j+7:8j. In 8-bit mode only chip_we_n_o[0] and chip_dout_o[7:0] are used, and chip_we_n_o[1] stays high.
- R8: chip_oe_n_o is low only during refill accesses, and chip_drive_o is high only during write accesses. The two are never active together, and a strobe is never low without the bus driven.
- R9: done_o is a one-cycle pulse in the cycle after the last access. busy_o is high from the cycle after acceptance through the done cycle, for 8(ws+2) or 16(ws+2) cycles before done on a refill, and 2(ws+3) or 4(ws+3) on a write.
- R10: Requests that arrive while busy are ignored and leave nothing pending. If both requests arrive together while idle, the refill is taken and the write is dropped.
- R11: The wait-state count, the bus width, the address, the data and the byte enables are taken at acceptance. Changing them during an operation has no effect on its timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refill_req_i | input | 1 | Start a four-word line refill |
| write_req_i | input | 1 | Start a single-word writethrough |
| addr_i | input | WA_W | Word address |
| wdata_i | input | 32 | Write data |
| wbe_i | input | 4 | Byte enables, bit j for bits 8j+7:8j |
| map_ws_i | input | WS_W | Wait states from the memory-map lookup |
| map_byte_i | input | 1 | 1 = byte-wide device, 0 = 16-bit device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| fill_we_o | output | 1 | Refill word valid |
| fill_idx_o | output | 2 | Word index within the line |
| fill_data_o | output | 32 | Assembled refill word |
| chip_addr_o | output | WA_W+2 | SRAM address |
| chip_oe_n_o | output | 1 | SRAM output enable, active low |
| chip_we_n_o | output | 2 | SRAM byte write strobes, active low |
| chip_dout_o | output | 16 | Data to SRAM |
| chip_drive_o | output | 1 | Data bus drive enable |
| chip_din_i | input | 16 | Data from SRAM |

## Verification
The hardest point to reach from the ports is the read-capture instant. A design that samples one cycle early still returns plausible data unless the memory itself punishes early sampling. The bench's memory model therefore returns a garbage value until the address has been stable with output enable low for ws+1 cycles. This makes a missing hold cycle or a miscounted wait state corrupt the data. Every bus width and wait-state count from 0 to 3 is swept. Writes go through all sixteen byte-enable patterns, including the all-zero one that must still consume both accesses. Mid-operation disturbance of the lookup inputs and of the request lines is covered as well.

// File: rtl/sram_seq_pkg.sv
// Shared types and helpers for the narrow SRAM sequencer.
// Assumes: line of four 32-bit words; bus at most 16 bits wide.
package sram_seq_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BUS_W      = 16;
    localparam int unsigned LANES      = 2;
    localparam int unsigned LINE_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STB,
        ST_RD_HLD,
        ST_WR_SET,
        ST_WR_STB,
        ST_WR_HLD,
        ST_FIN
    } seq_state_t;

    // Index of the final access of one word for the selected bus width.
    function automatic logic [1:0] last_phase(input logic byte_mode);
        return byte_mode ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
// Sequencer state machine: accepts requests while idle, latches the
// lookup result and the write payload, then steps through phases, words
// and wait-state counts. Assumes requests are single-cycle or level;
// anything arriving while busy is dropped.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned WA_W = 16,
    parameter int unsigned WS_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  refill_req_i,
    input  logic                  write_req_i,
    input  logic [WA_W-1:0]       addr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic [WORD_W/8-1:0]   wbe_i,
    input  logic [WS_W-1:0]       map_ws_i,
    input  logic                  map_byte_i,
    output seq_state_t            state_o,
    output logic [1:0]            phase_o,
    output logic [WA_W-1:0]       word_o,
    output logic                  byte_mode_o,
    output logic [WORD_W-1:0]     wdata_o,
    output logic [WORD_W/8-1:0]   wbe_o,
    output logic                  capture_o,
    output logic                  word_end_o,
    output logic [$clog2(LINE_WORDS)-1:0] word_idx_o,
    output logic                  busy_o,
    output logic                  done_o
);

    localparam int unsigned IDX_W = $clog2(LINE_WORDS);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(LINE_WORDS - 1);

    seq_state_t          state_q, state_d;
    logic [1:0]          ph_q, ph_d;
    logic [IDX_W-1:0]    wcnt_q, wcnt_d;
    logic [WS_W-1:0]     tcnt_q, tcnt_d;
    logic [WS_W-1:0]     ws_q;
    logic                byte_q;
    logic [WA_W-1:0]     base_q;
    logic [WORD_W-1:0]   wdata_q;
    logic [WORD_W/8-1:0] wbe_q;
    logic                accept;
    logic                last_ph;
    logic                wait_over;
    logic                is_read;

    assign accept    = (state_q == ST_IDLE) && (refill_req_i || write_req_i);
    assign last_ph   = (ph_q == last_phase(byte_q));
    assign wait_over = (tcnt_q == ws_q);
    assign is_read   = (state_q == ST_RD_STB) || (state_q == ST_RD_HLD);

    // Next-state and counter stepping for every phase of an operation.
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        wcnt_d  = wcnt_q;
        tcnt_d  = tcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                ph_d   = 2'd0;
                wcnt_d = '0;
                tcnt_d = '0;
                if (refill_req_i) begin
                    state_d = ST_RD_STB;
                end else if (write_req_i) begin
                    state_d = ST_WR_SET;
                end
            end
            ST_RD_STB: begin
                if (wait_over) begin
                    tcnt_d  = '0;
                    state_d = ST_RD_HLD;
                end else begin
                    tcnt_d = tcnt_q + 1'b1;
                end
            end
            ST_RD_HLD: begin
                if (last_ph) begin
                    ph_d = 2'd0;
                    if (wcnt_q == LAST_WORD) begin
                        state_d = ST_FIN;
                    end else begin
                        wcnt_d  = wcnt_q + 1'b1;
                        state_d = ST_RD_STB;
                    end
                end else begin
                    ph_d    = ph_q + 2'd1;
                    state_d = ST_RD_STB;
                end
            end
            ST_WR_SET: begin
                tcnt_d  = '0;
                state_d = ST_WR_STB;
            end
            ST_WR_STB: begin
                if (wait_over) begin
                    tcnt_d  = '0;
                    state_d = ST_WR_HLD;
                end else begin
                    tcnt_d = tcnt_q + 1'b1;
                end
            end
            ST_WR_HLD: begin
                if (last_ph) begin
                    state_d = ST_FIN;
                end else begin
                    ph_d    = ph_q + 2'd1;
                    state_d = ST_WR_SET;
                end
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 2'd0;
            wcnt_q  <= '0;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            wcnt_q  <= wcnt_d;
            tcnt_q  <= tcnt_d;
        end
    end

    // Operation context captured once, at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q    <= '0;
            byte_q  <= 1'b0;
            base_q  <= '0;
            wdata_q <= '0;
            wbe_q   <= '0;
        end else if (accept) begin
            ws_q    <= map_ws_i;
            byte_q  <= map_byte_i;
            wdata_q <= wdata_i;
            wbe_q   <= wbe_i;
            if (refill_req_i) begin
                base_q <= {addr_i[WA_W-1:IDX_W], {IDX_W{1'b0}}};
            end else begin
                base_q <= addr_i;
            end
        end
    end

    assign state_o     = state_q;
    assign phase_o     = ph_q;
    assign word_o      = is_read ? {base_q[WA_W-1:IDX_W], wcnt_q} : base_q;
    assign byte_mode_o = byte_q;
    assign wdata_o     = wdata_q;
    assign wbe_o       = wbe_q;
    assign capture_o   = (state_q == ST_RD_HLD);
    assign word_end_o  = (state_q == ST_RD_HLD) && last_ph;
    assign word_idx_o  = wcnt_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FIN);

endmodule

// File: rtl/sram_seq_bus.sv
// Pin decoder: derives chip address, output enable, byte strobes and
// write data from the registered sequencer state. Assumes the state,
// phase and payload inputs change only on clock edges.
module sram_seq_bus
    import sram_seq_pkg::*;
#(
    parameter int unsigned WA_W = 16,
    parameter int unsigned CA_W = WA_W + 2
) (
    input  seq_state_t            state_i,
    input  logic [1:0]            phase_i,
    input  logic [WA_W-1:0]       word_i,
    input  logic                  byte_mode_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic [WORD_W/8-1:0]   wbe_i,
    output logic [CA_W-1:0]       chip_addr_o,
    output logic                  chip_oe_n_o,
    output logic [LANES-1:0]      chip_we_n_o,
    output logic [BUS_W-1:0]      chip_dout_o,
    output logic                  chip_drive_o
);

    logic rd_phase;
    logic wr_phase;
    logic strobe;

    assign rd_phase = (state_i == ST_RD_STB) || (state_i == ST_RD_HLD);
    assign wr_phase = (state_i == ST_WR_SET) || (state_i == ST_WR_STB) ||
                      (state_i == ST_WR_HLD);
    assign strobe   = (state_i == ST_WR_STB);

    // Word address scaled by bus width, low bits from the access phase.
    always_comb begin
        if (byte_mode_i) begin
            chip_addr_o = {word_i, phase_i};
        end else begin
            chip_addr_o = {1'b0, word_i, phase_i[0]};
        end
    end

    assign chip_oe_n_o  = !rd_phase;
    assign chip_drive_o = wr_phase;

    // One byte lane per instance: pick the word byte and its enable.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [1:0] bidx;
        logic       lane_on;

        // Which byte of the word this lane carries in the current phase.
        always_comb begin
            if (byte_mode_i) begin
                bidx    = 2'd3 - phase_i;
                lane_on = (l == 0);
            end else begin
                bidx    = {~phase_i[0], 1'(l)};
                lane_on = 1'b1;
            end
        end

        assign chip_we_n_o[l]       = !(strobe && lane_on && wbe_i[bidx]);
        assign chip_dout_o[8*l +: 8] = (wr_phase && lane_on) ?
                                       wdata_i[8*bidx +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_seq_pack.sv
// Read assembler: shifts each captured halfword or byte into a 32-bit
// accumulator, most significant part first, and presents the finished
// word with its line index for one cycle. Assumes capture strobes come
// only at the end of read hold cycles.
module sram_seq_pack
    import sram_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic               word_end_i,
    input  logic               byte_mode_i,
    input  logic [IDX_W-1:0]   word_idx_i,
    input  logic [BUS_W-1:0]   din_i,
    output logic               fill_we_o,
    output logic [IDX_W-1:0]   fill_idx_o,
    output logic [WORD_W-1:0]  fill_data_o
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_next;

    // Shift-in of the current access, width chosen by bus mode.
    always_comb begin
        if (byte_mode_i) begin
            acc_next = {acc_q[WORD_W-9:0], din_i[7:0]};
        end else begin
            acc_next = {acc_q[WORD_W-BUS_W-1:0], din_i};
        end
    end

    // Accumulator update on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (capture_i) begin
            acc_q <= acc_next;
        end
    end

    // Registered hand-off of a completed word to the cache array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_we_o   <= 1'b0;
            fill_idx_o  <= '0;
            fill_data_o <= '0;
        end else begin
            fill_we_o <= capture_i && word_end_i;
            if (capture_i && word_end_i) begin
                fill_idx_o  <= word_idx_i;
                fill_data_o <= acc_next;
            end
        end
    end

endmodule

// File: rtl/sram_narrow_seq.sv
// Top of the narrow SRAM sequencer: line refills of four words and
// single-word writethroughs over a 16-bit or 8-bit static memory bus,
// with wait states from the memory-map lookup. Assumes the lookup
// outputs are valid in the cycle a request is presented.
module sram_narrow_seq
    import sram_seq_pkg::*;
#(
    parameter int unsigned WA_W = 16,
    parameter int unsigned WS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill_req_i,
    input  logic              write_req_i,
    input  logic [WA_W-1:0]   addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        wbe_i,
    input  logic [WS_W-1:0]   map_ws_i,
    input  logic              map_byte_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fill_we_o,
    output logic [1:0]        fill_idx_o,
    output logic [31:0]       fill_data_o,
    output logic [WA_W+1:0]   chip_addr_o,
    output logic              chip_oe_n_o,
    output logic [1:0]        chip_we_n_o,
    output logic [15:0]       chip_dout_o,
    output logic              chip_drive_o,
    input  logic [15:0]       chip_din_i
);

    localparam int unsigned CA_W  = WA_W + 2;
    localparam int unsigned IDX_W = $clog2(LINE_WORDS);

    seq_state_t          state;
    logic [1:0]          phase;
    logic [WA_W-1:0]     word;
    logic                byte_mode;
    logic [WORD_W-1:0]   wdata_q;
    logic [WORD_W/8-1:0] wbe_q;
    logic                capture;
    logic                word_end;
    logic [IDX_W-1:0]    word_idx;

    sram_seq_ctrl #(
        .WA_W (WA_W),
        .WS_W (WS_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .refill_req_i (refill_req_i),
        .write_req_i  (write_req_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .wbe_i        (wbe_i),
        .map_ws_i     (map_ws_i),
        .map_byte_i   (map_byte_i),
        .state_o      (state),
        .phase_o      (phase),
        .word_o       (word),
        .byte_mode_o  (byte_mode),
        .wdata_o      (wdata_q),
        .wbe_o        (wbe_q),
        .capture_o    (capture),
        .word_end_o   (word_end),
        .word_idx_o   (word_idx),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    sram_seq_bus #(
        .WA_W (WA_W),
        .CA_W (CA_W)
    ) u_bus (
        .state_i      (state),
        .phase_i      (phase),
        .word_i       (word),
        .byte_mode_i  (byte_mode),
        .wdata_i      (wdata_q),
        .wbe_i        (wbe_q),
        .chip_addr_o  (chip_addr_o),
        .chip_oe_n_o  (chip_oe_n_o),
        .chip_we_n_o  (chip_we_n_o),
        .chip_dout_o  (chip_dout_o),
        .chip_drive_o (chip_drive_o)
    );

    sram_seq_pack #(
        .IDX_W (IDX_W)
    ) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (capture),
        .word_end_i  (word_end),
        .byte_mode_i (byte_mode),
        .word_idx_i  (word_idx),
        .din_i       (chip_din_i),
        .fill_we_o   (fill_we_o),
        .fill_idx_o  (fill_idx_o),
        .fill_data_o (fill_data_o)
    );

endmodule

// File: rtl/sram_seq_chk.sv
// Protocol checker for the narrow SRAM sequencer, attached by bind.
// Observes only the top-level pins.
module sram_seq_chk #(
    parameter int unsigned CA_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            done_o,
    input logic            fill_we_o,
    input logic [CA_W-1:0] chip_addr_o,
    input logic            chip_oe_n_o,
    input logic [1:0]      chip_we_n_o,
    input logic [15:0]     chip_dout_o,
    input logic            chip_drive_o
);

    // R8
    oe_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!chip_oe_n_o && chip_drive_o));

    // R8
    strobe_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_we_n_o != 2'b11) |-> chip_drive_o);

    // R6
    strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((chip_we_n_o != 2'b11) && ($past(chip_we_n_o) == 2'b11))
        |-> ($stable(chip_addr_o) && $stable(chip_dout_o) && $past(chip_drive_o)));

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((chip_we_n_o == 2'b11) && ($past(chip_we_n_o) != 2'b11))
        |-> (chip_drive_o && $stable(chip_addr_o) && $stable(chip_dout_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R2
    fill_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we_o |-> busy_o);

endmodule

bind sram_narrow_seq sram_seq_chk #(.CA_W(WA_W + 2)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fill_we_o    (fill_we_o),
    .chip_addr_o  (chip_addr_o),
    .chip_oe_n_o  (chip_oe_n_o),
    .chip_we_n_o  (chip_we_n_o),
    .chip_dout_o  (chip_dout_o),
    .chip_drive_o (chip_drive_o)
);

// File: tb/test_sram_narrow_seq.sv
`timescale 1ns/1ps
module test_sram_narrow_seq;

    localparam int WA_W  = 8;
    localparam int WS_W  = 3;
    localparam int CA_W  = WA_W + 2;
    localparam int DEPTH = 1 << CA_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            refill_req = 1'b0;
    logic            write_req = 1'b0;
    logic [WA_W-1:0] addr = '0;
    logic [31:0]     wdata = '0;
    logic [3:0]      wbe = '0;
    logic [WS_W-1:0] map_ws = '0;
    logic            map_byte = 1'b0;
    logic            busy, done, fill_we, chip_drive, chip_oe_n;
    logic [1:0]      fill_idx, chip_we_n;
    logic [31:0]     fill_data;
    logic [CA_W-1:0] chip_addr;
    logic [15:0]     chip_dout;
    logic [15:0]     chip_din;

    always #2.5 clk = ~clk;

    sram_narrow_seq #(.WA_W(WA_W), .WS_W(WS_W)) i_sram_narrow_seq (
        .clk(clk), .rst_n(rst_n), .refill_req_i(refill_req),
        .write_req_i(write_req), .addr_i(addr), .wdata_i(wdata),
        .wbe_i(wbe), .map_ws_i(map_ws), .map_byte_i(map_byte),
        .busy_o(busy), .done_o(done), .fill_we_o(fill_we),
        .fill_idx_o(fill_idx), .fill_data_o(fill_data),
        .chip_addr_o(chip_addr), .chip_oe_n_o(chip_oe_n),
        .chip_we_n_o(chip_we_n), .chip_dout_o(chip_dout),
        .chip_drive_o(chip_drive), .chip_din_i(chip_din)
    );

    // Bench memory models and operation context
    logic [15:0] mem16 [DEPTH];
    logic [7:0]  mem8  [DEPTH];
    bit          dev8 = 1'b0;
    int          cur_ws = 0;
    int          cur_op = 0;
    int          checks = 0;
    int          fails = 0;
    int          stab = 0;
    logic [CA_W-1:0] prev_a = '0;
    int          run = 0, runs = 0, badrun = 0, viol = 0, nfill = 0;
    logic [31:0] got [4];
    int          gidx [4];

    // Access-time model: data valid only after ws+1 stable cycles
    always @(negedge clk) begin
        if (chip_oe_n || chip_addr != prev_a) stab <= 0;
        else stab <= stab + 1;
        prev_a <= chip_addr;
    end

    always_comb begin
        if (!chip_oe_n && stab >= cur_ws + 1)
            chip_din = dev8 ? {8'hEE, mem8[chip_addr]} : mem16[chip_addr];
        else
            chip_din = 16'hBAD1;
    end

    // Write model, strobe-length monitor, bus policy and fill capture
    always @(negedge clk) begin
        if (!chip_we_n[0]) begin
            if (dev8) mem8[chip_addr] = chip_dout[7:0];
            else mem16[chip_addr][7:0] = chip_dout[7:0];
        end
        if (!chip_we_n[1]) begin
            if (dev8) viol++;
            else mem16[chip_addr][15:8] = chip_dout[15:8];
        end
        if (chip_we_n != 2'b11) begin
            run++;
        end else if (run != 0) begin
            runs++;
            if (run != cur_ws + 1) badrun++;
            run = 0;
        end
        if (!chip_oe_n && chip_drive) viol++;
        if (!chip_oe_n && cur_op == 2) viol++;
        if (chip_drive && cur_op == 1) viol++;
        if (chip_we_n != 2'b11 && !chip_drive) viol++;
        if (fill_we) begin
            if (nfill < 4) begin
                got[nfill]  = fill_data;
                gidx[nfill] = int'(fill_idx);
            end
            nfill++;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ca(input int word, input int ph, input bit b8);
        return b8 ? (word * 4 + ph) : (word * 2 + ph);
    endfunction

    // Runs one operation; disturb changes inputs mid-flight (R10, R11)
    task automatic run_op(input bit is_rd, input bit both, input bit b8,
                          input int ws, input logic [WA_W-1:0] wa,
                          input logic [31:0] wd, input logic [3:0] be,
                          input bit disturb, output int lat);
        int guard;
        @(negedge clk);
        dev8 = b8; cur_ws = ws; cur_op = is_rd ? 1 : 2;
        nfill = 0; runs = 0; badrun = 0; viol = 0;
        map_ws = WS_W'(ws); map_byte = b8; addr = wa; wdata = wd; wbe = be;
        refill_req = is_rd; write_req = !is_rd || both;
        @(negedge clk);
        refill_req = 0; write_req = 0;
        if (disturb) begin
            map_ws = ~WS_W'(ws); map_byte = ~b8;
            addr = ~wa; wdata = ~wd; wbe = ~be;
        end
        lat = 0; guard = 0;
        forever begin
            if (done || guard >= 4000) break;
            if (busy) lat++;
            guard++;
            if (disturb && guard == 3) begin refill_req = 1; write_req = 1; end
            if (disturb && guard == 4) begin refill_req = 0; write_req = 0; end
            @(negedge clk);
        end
        check(guard < 4000, "R9 done never seen", guard, 0);
        @(negedge clk);
        @(negedge clk);
        cur_op = 0;
        // R10: nothing pending after the op
        check(!busy, "R10 idle after done", busy, 0);
    endtask

    task automatic do_refill(input bit b8, input int ws,
                             input logic [WA_W-1:0] wa, input bit both,
                             input bit disturb);
        logic [31:0] exp [4];
        logic [15:0] snap [8];
        int lb, lat, acc;
        lb = int'(wa) & ~3;
        acc = b8 ? 4 : 2;
        for (int i = 0; i < 4; i++) begin
            if (b8) exp[i] = {mem8[ca(lb+i,0,1)], mem8[ca(lb+i,1,1)],
                              mem8[ca(lb+i,2,1)], mem8[ca(lb+i,3,1)]};
            else    exp[i] = {mem16[ca(lb+i,0,0)], mem16[ca(lb+i,1,0)]};
        end
        for (int i = 0; i < 8; i++) snap[i] = mem16[ca(int'(wa),i%2,0)];
        run_op(1'b1, both, b8, ws, wa, 32'h13579BDF, 4'hF, disturb, lat);
        // R9 R4: busy length of a refill
        check(lat == 4 * acc * (ws + 2), "R9 R4 refill busy cycles", lat, 4 * acc * (ws + 2));
        // R2: four fills
        check(nfill == 4, "R2 fill count", nfill, 4);
        for (int i = 0; i < 4; i++) begin
            check(gidx[i] == i, "R2 fill index order", gidx[i], i);
            check(got[i] == exp[i], "R2 R3 R4 fill data", got[i], exp[i]);
        end
        // R8: bus policy during the refill
        check(viol == 0, "R8 bus policy", viol, 0);
        if (both) begin
            // R10: dropped write left memory unchanged
            for (int i = 0; i < 2; i++)
                check(mem16[ca(int'(wa),i,0)] == snap[i], "R10 write dropped",
                      mem16[ca(int'(wa),i,0)], snap[i]);
        end
    endtask

    task automatic do_write(input bit b8, input int ws,
                            input logic [WA_W-1:0] wa, input logic [31:0] wd,
                            input logic [3:0] be, input bit disturb);
        logic [15:0] e16 [2];
        logic [7:0]  e8 [4];
        int lat, acc, exp_runs;
        acc = b8 ? 4 : 2;
        for (int p = 0; p < 2; p++) e16[p] = mem16[ca(int'(wa),p,0)];
        for (int p = 0; p < 4; p++) e8[p] = mem8[ca(int'(wa),p,1)];
        exp_runs = 0;
        if (b8) begin
            for (int p = 0; p < 4; p++)
                if (be[3-p]) begin e8[p] = wd[8*(3-p) +: 8]; exp_runs++; end
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (be[3-2*p]) e16[p][15:8] = wd[8*(3-2*p) +: 8];
                if (be[2-2*p]) e16[p][7:0]  = wd[8*(2-2*p) +: 8];
                if (be[3-2*p] || be[2-2*p]) exp_runs++;
            end
        end
        run_op(1'b0, 1'b0, b8, ws, wa, wd, be, disturb, lat);
        // R5 R6 R9: every access costs ws+3 cycles, all accesses taken
        check(lat == acc * (ws + 3), "R5 R6 R9 write busy cycles", lat, acc * (ws + 3));
        // R5 R6: strobes only for enabled accesses, each ws+1 long
        check(runs == exp_runs, "R5 strobe count", runs, exp_runs);
        check(badrun == 0, "R6 strobe length", badrun, 0);
        check(viol == 0, "R7 R8 bus policy", viol, 0);
        // R7: byte lanes land where expected
        if (b8) begin
            for (int p = 0; p < 4; p++)
                check(mem8[ca(int'(wa),p,1)] == e8[p], "R7 byte memory",
                      mem8[ca(int'(wa),p,1)], e8[p]);
        end else begin
            for (int p = 0; p < 2; p++)
                check(mem16[ca(int'(wa),p,0)] == e16[p], "R7 halfword memory",
                      mem16[ca(int'(wa),p,0)], e16[p]);
        end
    endtask

    // Run-time limit: counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            mem16[a] = 16'((a * 40503) ^ 23130);
            mem8[a]  = 8'((a * 29) ^ 195);
        end
        repeat (4) @(negedge clk);
        // R1: outputs while in reset
        check(!busy && !done && !fill_we, "R1 status in reset", {busy, done, fill_we}, 0);
        check(chip_oe_n && chip_we_n == 2'b11 && !chip_drive, "R1 pins in reset",
              {chip_oe_n, chip_we_n, chip_drive}, 4'b1110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && chip_oe_n && chip_we_n == 2'b11 && !chip_drive,
              "R1 idle after reset", {busy, chip_oe_n, chip_we_n, chip_drive}, 5'b01110);

        // R2 R3 R4: refills over both widths and all small wait counts
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++) begin
                do_refill(b[0], w, 8'h84, 1'b0, 1'b0);
                do_refill(b[0], w, 8'h07, 1'b0, 1'b0);
                do_refill(b[0], w, 8'hFF, 1'b0, 1'b0);
            end

        // R5 R6 R7: every byte-enable pattern, both widths, ws 0..3
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 4; w++)
                for (int e = 0; e < 16; e++)
                    do_write(b[0], w, WA_W'(8'h20 + e + 16 * w),
                             32'hA1B2C3D4 ^ (e * 32'h01010101), 4'(e), 1'b0);

        // R2: read back a written line through a refill
        do_write(1'b0, 1, 8'h40, 32'hCAFEF00D, 4'hF, 1'b0);
        do_refill(1'b0, 1, 8'h41, 1'b0, 1'b0);
        check(got[0] == 32'hCAFEF00D, "R2 readback of write", got[0], 32'hCAFEF00D);

        // R11 R10: lookup and payload changed mid-op, requests while busy
        do_refill(1'b0, 2, 8'h90, 1'b0, 1'b1);
        do_refill(1'b1, 1, 8'h34, 1'b0, 1'b1);
        do_write(1'b0, 2, 8'h55, 32'h0BADBEEF, 4'b1010, 1'b1);
        do_write(1'b1, 0, 8'h66, 32'h76543210, 4'b0110, 1'b1);

        // R10: both requests together while idle, refill wins
        do_refill(1'b0, 1, 8'h40, 1'b1, 1'b0);
        do_refill(1'b1, 0, 8'h12, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule